// File: doc/BRIEF.md
# Eight-Lane Serial Audio Capture with Shared Word Queue

This block takes in up to eight stereo serial audio streams. Each stream comes on its own bit clock, word-select (frame sync) line and data line. Each lane brings its three pins into the system clock domain and samples a data bit on every detected rising bit-clock edge. It turns every half of a 64-slot frame (32 bit-clock slots for the left sample, 32 for the right) into one 32-bit word. The sample sits in the upper bits of that word and the bits below it are zero.

Completed words wait in a one-word holding slot inside each lane. A rotating-priority arbiter moves at most one of them per clock into a single eight-entry queue. A consumer drains the queue with a valid/ready handshake. Each queue entry carries the sample word, the lane number and a left/right flag.

Each lane has its own enable input and its own 3-bit format code. When a lane's held word is replaced before it reaches the queue, the lane raises a sticky overflow flag.

Top module: `ssai_top`

## Requirements
- R1: After reset, `o_valid` is 0 and every bit of `o_overflow` is 0.
- R2: While `o_valid` is 1 and `i_ready` is 0, `o_valid`, `o_data`, `o_chan` and `o_left` hold their values. An entry leaves the queue only on a clock where both `o_valid` and `i_ready` are 1.
- R3: Left-justified formats use code 2 (24-bit) and code 3 (32-bit). A high word-select marks the left half, and the sample MSB is sampled on the first rising bit-clock edge of the half.
- R4: I2S formats use code 0 (24-bit) and code 1 (32-bit). A low word-select marks the left half, and the sample MSB is sampled on the second rising edge of the half. The LSB of a 32-bit sample falls on the first edge of the following half.
- R5: Right-justified formats use code 4 (24-bit), code 5 (20-bit), code 6 (18-bit) and code 7 (16-bit). A high word-select marks the left half, and the sample LSB is sampled on the last (32nd) rising edge of the half.
- R6: A W-bit sample is delivered in `o_data[31:32-W]` with zeros below it. `o_chan` is the lane index (0 to 7) and `o_left` is 1 for a left-half sample.
- R7: Every complete half-frame of an enabled lane yields exactly one queue entry. A lane's entries leave in the order they arrived.
- R8: At most one lane is granted per clock, and only a lane with a pending word. When all eight lanes have words at once, they are granted in consecutive lane order, wrapping from 7 to 0.
- R9: When a lane completes a word while its previous word is still waiting, the older word is lost, the newer one is kept, and that lane's `o_overflow` bit becomes 1. The bit stays 1 while the lane stays enabled.
- R10: A lane whose enable is 0 produces no entries. Its held word, shift state and overflow bit are cleared within one clock.
- R11: While the queue holds eight entries, no word is written into it. The eight held entries are delivered unchanged once the consumer drains them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_chan_en | input | 8 | Per-lane enable |
| i_chan_fmt | input | 24 | Per-lane format code, 3 bits per lane, lane n at [3n+2:3n] |
| i_bclk | input | 8 | Per-lane serial bit clock |
| i_fsync | input | 8 | Per-lane word-select / frame sync |
| i_sdata | input | 8 | Per-lane serial data |
| o_valid | output | 1 | Queue head is valid |
| i_ready | input | 1 | Consumer accepts the queue head |
| o_data | output | 32 | Sample word, MSB-aligned |
| o_chan | output | 3 | Lane number of the head entry |
| o_left | output | 1 | 1 when the head entry is a left sample |
| o_overflow | output | 8 | Sticky per-lane overflow flags |

## Verification
A lane that loses its slot count or latches the wrong word-select polarity shows up in the first frame after enable. It produces a shifted sample, swapped left/right flags, or an extra or missing word, and every one of these is visible on the first pop for that half.

An arbiter pointer fault shows within a single eight-lane burst, as a non-consecutive lane sequence. A faulty overflow or clear path shows in the flag bits within a clock of the triggering frame or disable, and in which words survive the later drain.

// File: rtl/ssai_pkg.sv
package ssai_pkg;

    localparam int WORD_W = 32;
    localparam int SLOT_W = 6;

    typedef enum logic [2:0] {
        FMT_I2S24 = 3'd0,
        FMT_I2S32 = 3'd1,
        FMT_LJ24  = 3'd2,
        FMT_LJ32  = 3'd3,
        FMT_RJ24  = 3'd4,
        FMT_RJ20  = 3'd5,
        FMT_RJ18  = 3'd6,
        FMT_RJ16  = 3'd7
    } fmt_e;

    // Sample width of a format, in bits.
    function automatic logic [SLOT_W-1:0] fmt_bits(fmt_e f);
        case (f)
            FMT_I2S24, FMT_LJ24, FMT_RJ24: fmt_bits = 6'd24;
            FMT_RJ20:                      fmt_bits = 6'd20;
            FMT_RJ18:                      fmt_bits = 6'd18;
            FMT_RJ16:                      fmt_bits = 6'd16;
            default:                       fmt_bits = 6'd32;
        endcase
    endfunction

    // First slot of the half that carries sample data.
    function automatic logic [SLOT_W-1:0] fmt_lead(fmt_e f);
        case (f)
            FMT_RJ24, FMT_RJ20, FMT_RJ18, FMT_RJ16: fmt_lead = 6'd32 - fmt_bits(f);
            default:                                fmt_lead = 6'd0;
        endcase
    endfunction

    // I2S: word select is low for left and leads the data by one bit clock.
    function automatic logic fmt_delayed(fmt_e f);
        fmt_delayed = (f == FMT_I2S24) || (f == FMT_I2S32);
    endfunction

endpackage

// File: rtl/ssai_lane.sv
module ssai_lane
    import ssai_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  fmt_e              fmt,
    input  logic              bclk_i,
    input  logic              fs_i,
    input  logic              sd_i,
    input  logic              grant,
    output logic              pend_valid,
    output logic [WORD_W-1:0] pend_word,
    output logic              pend_left,
    output logic              ovf
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sb;
        logic [SYNC_STAGES-1:0] sf;
        logic [SYNC_STAGES-1:0] sdt;
        logic                   bprev;
        logic                   fsdly;
        logic                   effprev;
        logic [SLOT_W-1:0]      slot;
        logic [WORD_W-1:0]      sh;
        logic                   pv;
        logic [WORD_W-1:0]      pw;
        logic                   pl;
        logic                   ovf;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic              bc, fsv, dv, rise, eff, newhalf;
    logic [SLOT_W-1:0] wbits, lead, sn;
    logic [WORD_W-1:0] shn;

    always_comb begin
        st_d    = st_q;
        bc      = st_q.sb[SYNC_STAGES-1];
        fsv     = st_q.sf[SYNC_STAGES-1];
        dv      = st_q.sdt[SYNC_STAGES-1];
        rise    = bc & ~st_q.bprev;
        wbits   = fmt_bits(fmt);
        lead    = fmt_lead(fmt);
        eff     = fmt_delayed(fmt) ? ~st_q.fsdly : fsv;
        newhalf = (eff != st_q.effprev);
        sn      = newhalf ? '0 : ((st_q.slot == '1) ? st_q.slot : st_q.slot + 1'b1);
        shn     = (sn == lead) ? {{(WORD_W-1){1'b0}}, dv} : {st_q.sh[WORD_W-2:0], dv};

        st_d.sb    = {st_q.sb[SYNC_STAGES-2:0], bclk_i};
        st_d.sf    = {st_q.sf[SYNC_STAGES-2:0], fs_i};
        st_d.sdt   = {st_q.sdt[SYNC_STAGES-2:0], sd_i};
        st_d.bprev = bc;

        if (grant) st_d.pv = 1'b0;

        if (!en) begin
            st_d.fsdly   = 1'b1;
            st_d.effprev = 1'b0;
            st_d.slot    = '1;
            st_d.sh      = '0;
            st_d.pv      = 1'b0;
            st_d.ovf     = 1'b0;
        end else if (rise) begin
            st_d.fsdly   = fsv;
            st_d.effprev = eff;
            st_d.slot    = sn;
            if (sn >= lead && sn < lead + wbits) begin
                st_d.sh = shn;
                if (sn == lead + wbits - 1'b1) begin
                    if (st_q.pv && !grant) st_d.ovf = 1'b1;
                    st_d.pv = 1'b1;
                    st_d.pw = shn << (6'd32 - wbits);
                    st_d.pl = eff;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fsdly <= 1'b1;
            st_q.slot  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_valid = st_q.pv;
    assign pend_word  = st_q.pw;
    assign pend_left  = st_q.pl;
    assign ovf        = st_q.ovf;

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.ovf) |=> st_q.ovf);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pend_valid && !ovf));

endmodule

// File: rtl/ssai_rr_arb.sv
module ssai_rr_arb #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          allow,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gidx,
    output logic          gvalid
);

    logic [IW-1:0] last_d, last_q;

    always_comb begin
        grant  = '0;
        gidx   = '0;
        gvalid = 1'b0;
        last_d = last_q;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last_q) + k) % N;
            if (!gvalid && allow && req[j]) begin
                gvalid   = 1'b1;
                grant[j] = 1'b1;
                gidx     = IW'(j);
            end
        end
        if (gvalid) last_d = gidx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IW'(N - 1);
        else        last_q <= last_d;
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

endmodule

// File: rtl/ssai_fifo.sv
module ssai_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rp;
        logic [AW-1:0]           wp;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != (AW+1)'(DEPTH));
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = st_q.wp + 1'b1;
        end
        if (do_pop) st_d.rp = st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full  = (st_q.cnt == (AW+1)'(DEPTH));
    assign valid = (st_q.cnt != '0);
    assign rdata = st_q.mem[st_q.rp];

    assert_fifo_no_push_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/ssai_top.sv
module ssai_top
    import ssai_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int ENT_W      = CH_W + 1 + WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   i_chan_en,
    input  logic [3*NUM_CH-1:0] i_chan_fmt,
    input  logic [NUM_CH-1:0]   i_bclk,
    input  logic [NUM_CH-1:0]   i_fsync,
    input  logic [NUM_CH-1:0]   i_sdata,
    output logic                o_valid,
    input  logic                i_ready,
    output logic [WORD_W-1:0]   o_data,
    output logic [CH_W-1:0]     o_chan,
    output logic                o_left,
    output logic [NUM_CH-1:0]   o_overflow
);

    logic [NUM_CH-1:0] pv, pl, grant;
    logic [WORD_W-1:0] pw [NUM_CH];
    logic [CH_W-1:0]   gidx;
    logic              gvalid, full;
    logic [ENT_W-1:0]  wdata, rdata;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        ssai_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (i_chan_en[g]),
            .fmt        (fmt_e'(i_chan_fmt[3*g +: 3])),
            .bclk_i     (i_bclk[g]),
            .fs_i       (i_fsync[g]),
            .sd_i       (i_sdata[g]),
            .grant      (grant[g]),
            .pend_valid (pv[g]),
            .pend_word  (pw[g]),
            .pend_left  (pl[g]),
            .ovf        (o_overflow[g])
        );
    end

    ssai_rr_arb #(.N(NUM_CH)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (pv),
        .allow  (!full),
        .grant  (grant),
        .gidx   (gidx),
        .gvalid (gvalid)
    );

    assign wdata = {gidx, pl[gidx], pw[gidx]};

    ssai_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (gvalid),
        .wdata (wdata),
        .pop   (o_valid && i_ready),
        .full  (full),
        .valid (o_valid),
        .rdata (rdata)
    );

    assign o_chan = rdata[ENT_W-1 -: CH_W];
    assign o_left = rdata[WORD_W];
    assign o_data = rdata[WORD_W-1:0];

    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !i_ready) |=> (o_valid && $stable(o_data) && $stable(o_chan) && $stable(o_left)));

endmodule

// File: tb/sim_ssai_top.sv
module sim_ssai_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  en_r = '0;
    logic [23:0] fmt_r = '0;
    logic [7:0]  bclk_r = '0, fs_r = '0, sd_r = '0;
    logic        ready = 1'b1;
    logic        o_valid, o_left;
    logic [31:0] o_data;
    logic [2:0]  o_chan;
    logic [7:0]  o_overflow;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;

    logic [31:0] exp_data [8][16];
    bit          exp_left [8][16];
    int          exp_wr [8];
    int          exp_rd [8];
    string       cur_req = "R7";
    bit          rr_on = 1'b0;
    int          last_pop_cyc = -10;
    int          last_pop_ch = 0;

    always #(CLK_P/2) clk = ~clk;

    ssai_top u0 (
        .clk(clk), .rst_n(rst_n), .i_chan_en(en_r), .i_chan_fmt(fmt_r),
        .i_bclk(bclk_r), .i_fsync(fs_r), .i_sdata(sd_r),
        .o_valid(o_valid), .i_ready(ready), .o_data(o_data), .o_chan(o_chan),
        .o_left(o_left), .o_overflow(o_overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int bw(input int fm);
        case (fm)
            0, 2, 4: bw = 24;
            5:       bw = 20;
            6:       bw = 18;
            7:       bw = 16;
            default: bw = 32;
        endcase
    endfunction

    function automatic logic [31:0] samp(input int ch, input int f, input int h, input int fm);
        logic [63:0] v;
        v = 64'((32'h9E3779B9 * (ch*4 + f*2 + h + 1)) ^ 32'h5A5A0F0F);
        samp = 32'(v & ((64'd1 << bw(fm)) - 1));
    endfunction

    // bit of the undelayed stream at global slot t
    function automatic logic lj(input int fm, input int t, input int nfr, input int ch);
        int u, w, s;
        logic [31:0] v;
        if (t < 32 || t >= 32 + 64*nfr) return 1'b0;
        u = t - 32; s = u % 32; w = bw(fm);
        v = samp(ch, u / 64, (u % 64) / 32, fm);
        if (fm >= 4) return (s >= 32 - w) ? v[31 - s] : 1'b0;
        return (s < w) ? v[w - 1 - s] : 1'b0;
    endfunction

    function automatic logic fsl(input int fm, input int t, input int nfr);
        bit left;
        left = (t >= 32 && t < 32 + 64*nfr) && (((t - 32) % 64) < 32);
        fsl = (fm < 2) ? ~left : left;
    endfunction

    task automatic push_exp(input int ch, input int f, input int h, input int fm);
        exp_data[ch][exp_wr[ch] % 16] = samp(ch, f, h, fm) << (32 - bw(fm));
        exp_left[ch][exp_wr[ch] % 16] = (h == 0);
        exp_wr[ch]++;
    endtask

    task automatic cfg(input int fm, input logic [7:0] mask);
        @(negedge clk);
        en_r = '0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < 8; c++) fmt_r[3*c +: 3] = 3'(fm);
        fs_r = (fm < 2) ? 8'hFF : 8'h00;
        sd_r = '0; bclk_r = '0;
        repeat (6) @(negedge clk);
        en_r = mask;
        repeat (2) @(negedge clk);
    endtask

    task automatic stream(input int fm, input int nfr, input logic [7:0] mask, input bit expect_all);
        int total;
        if (expect_all)
            for (int c = 0; c < 8; c++)
                if (mask[c])
                    for (int f = 0; f < nfr; f++) begin
                        push_exp(c, f, 0, fm);
                        push_exp(c, f, 1, fm);
                    end
        total = 32 + 64*nfr + 2;
        for (int t = 0; t < total; t++) begin
            @(negedge clk);
            for (int c = 0; c < 8; c++) begin
                sd_r[c] = (fm < 2) ? ((t > 0) ? lj(fm, t-1, nfr, c) : 1'b0) : lj(fm, t, nfr, c);
                fs_r[c] = fsl(fm, t, nfr);
            end
            bclk_r = '0;
            @(negedge clk);
            @(negedge clk);
            bclk_r = 8'hFF;
            @(negedge clk);
        end
        @(negedge clk);
        bclk_r = '0;
        repeat (40) @(negedge clk);
    endtask

    task automatic check_drained(input string req);
        for (int c = 0; c < 8; c++)
            chk(exp_rd[c] == exp_wr[c], req, 64'(exp_rd[c]), 64'(exp_wr[c]));
        chk(o_valid == 1'b0, req, 64'(o_valid), 64'd0);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // pop monitor: samples after the negedge, the handshake is taken at the next posedge
    always @(negedge clk) begin
        #2;
        if (rst_n && o_valid && ready) begin
            int c, i;
            c = int'(o_chan);
            if (exp_rd[c] == exp_wr[c]) begin
                chk(1'b0, "R7 unexpected word", {29'd0, o_chan, o_data}, 64'd0);
            end else begin
                i = exp_rd[c] % 16;
                chk(o_data == exp_data[c][i], cur_req, 64'(o_data), 64'(exp_data[c][i]));
                chk(o_left == exp_left[c][i], "R6 left flag", 64'(o_left), 64'(exp_left[c][i]));
                exp_rd[c]++;
            end
            if (rr_on && last_pop_cyc == cyc - 1)
                chk(c == (last_pop_ch + 1) % 8, "R8 rotation", 64'(c), 64'((last_pop_ch + 1) % 8));
            last_pop_cyc = cyc;
            last_pop_ch  = c;
        end
    end

    initial begin
        logic [31:0] hd;
        logic [2:0]  hc;
        for (int c = 0; c < 8; c++) begin exp_wr[c] = 0; exp_rd[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(o_valid == 1'b0, "R1 valid", 64'(o_valid), 64'd0);
        chk(o_overflow == 8'h00, "R1 overflow", 64'(o_overflow), 64'd0);

        // R3 R4 R5 R6 R7 R8: sweep of all formats on all lanes
        rr_on = 1'b1;
        for (int fm = 0; fm < 8; fm++) begin
            cur_req = (fm < 2) ? "R4 i2s word" : ((fm < 4) ? "R3 left-justified word" : "R5 right-justified word");
            cfg(fm, 8'hFF);
            stream(fm, 2, 8'hFF, 1'b1);
            check_drained("R7 all halves delivered");
            chk(o_overflow == 8'h00, "R9 no overflow when drained", 64'(o_overflow), 64'd0);
        end
        rr_on = 1'b0;

        // R10: disabled lanes give nothing
        cur_req = "R10 masked lanes";
        cfg(5, 8'h5A);
        stream(5, 1, 8'h5A, 1'b1);
        check_drained("R10 only enabled lanes");

        // R9 R11 R2: consumer stalls across two frames
        cur_req = "R11 queue contents";
        cfg(3, 8'hFF);
        @(negedge clk); ready = 1'b0;
        stream(3, 2, 8'hFF, 1'b0);
        chk(o_overflow == 8'hFF, "R9 overflow set", 64'(o_overflow), 64'hFF);
        chk(o_valid == 1'b1, "R11 queue holds", 64'(o_valid), 64'd1);
        hd = o_data; hc = o_chan;
        repeat (5) @(negedge clk);
        chk(o_valid && o_data == hd && o_chan == hc, "R2 head held", {29'd0, o_chan, o_data}, {29'd0, hc, hd});
        for (int c = 0; c < 8; c++) push_exp(c, 0, 0, 3);
        for (int c = 0; c < 8; c++) push_exp(c, 1, 1, 3);
        ready = 1'b1;
        repeat (40) @(negedge clk);
        check_drained("R9 newest kept, R11 queue kept");
        chk(o_overflow == 8'hFF, "R9 overflow sticky", 64'(o_overflow), 64'hFF);

        // R10: disabling clears held word and overflow bit
        cur_req = "R10 after disable";
        ready = 1'b0;
        stream(3, 1, 8'hFF, 1'b0);
        chk(o_overflow == 8'hFF, "R9 still set", 64'(o_overflow), 64'hFF);
        en_r = 8'hF0;
        repeat (3) @(negedge clk);
        chk(o_overflow == 8'hF0, "R10 overflow cleared", 64'(o_overflow), 64'hF0);
        en_r = 8'hFF;
        for (int c = 0; c < 8; c++) push_exp(c, 0, 0, 3);
        for (int c = 4; c < 8; c++) push_exp(c, 0, 1, 3);
        ready = 1'b1;
        repeat (40) @(negedge clk);
        check_drained("R10 held words dropped");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule